// File: doc/BRIEF.md
# Power-Fail Bus Access Gate

This block stands between a host bus and a battery-backed timekeeping device. It passes the host's two active-low selects (one for the timekeeping registers, one for the extended memory) and its active-low read and write strobes to the device only while the supply is healthy. While the supply is low, every line toward the device is held inactive and the data-output enable is held off. The device therefore ignores the bus and its data pins stay in high impedance.

When the supply-good flag comes back, access stays blocked for a fixed stabilisation interval of 200 ms. That interval is counted in clock cycles as `CLK_HZ/1000*LOCK_MS`, so a bench can shrink it. Access is also granted only when the device reports that its oscillator and countdown chain are running. A second flag marks the switch to the backup source. It blocks access on its own, so the timekeeping state cannot be touched while the device runs from the backup source.

A bus line that is held active across a blocked period is not passed again until the host releases it. This aborts a write that power loss interrupted, and it stops a half-finished cycle from resuming after recovery. The block has no data path, so all of its pins are plain control levels with no valid/ready handshake.

Top module: `pwrfail_access_gate`

## Requirements
- R1: After reset, all four device lines (`dev_cs_time_n`, `dev_cs_mem_n`, `dev_rd_n`, `dev_wr_n`) are high and `dout_en` is 0.
- R2: While the synchronised supply-good flag is low, all four device lines are high (inactive), whatever levels the host drives.
- R3: `dout_en` is 0 whenever access is blocked. While access is granted, `dout_en` is 1 exactly when the passed `dev_rd_n` is low and at least one passed select is low.
- R4: The supply-good flag passes through a two-flop synchroniser. After it rises, with the host idle and the oscillator running, access is still blocked after L+1 clock edges and granted after L+2 edges, where L = CLK_HZ/1000*LOCK_MS.
- R5: If the supply-good flag drops during the lockout interval, the count restarts, and a later rise again needs the full L+2 edges before access is granted.
- R6: Access is granted only while `osc_run` is high. `osc_run` is synchronous to `clk` and acts on the gate within the same cycle.
- R7: While the synchronised backup-switch flag is high, access is blocked, even if supply-good is high. Once the flag clears, the full lockout must elapse again; the flag acts two edges after it changes.
- R8: A host line that is low at any clock edge while access is blocked stays inactive at the device until the host drives it high at a clock edge.
- R9: While access is granted and a line is armed, each device line equals its host line in the same cycle, with no register delay.
- R10: A supply-good fall blocks access two clock edges later. This aborts a write in progress: `dev_wr_n` and the select go high even if the host still holds them low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_time_n | input | 1 | Host select for timekeeping registers, active low |
| host_cs_mem_n | input | 1 | Host select for extended memory, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| supply_ok | input | 1 | Supply above access threshold, asynchronous |
| on_backup | input | 1 | Device switched to backup source, asynchronous |
| osc_run | input | 1 | Device oscillator and countdown chain running, synchronous |
| dev_cs_time_n | output | 1 | Gated timekeeping select, active low |
| dev_cs_mem_n | output | 1 | Gated memory select, active low |
| dev_rd_n | output | 1 | Gated read strobe, active low |
| dev_wr_n | output | 1 | Gated write strobe, active low |
| dout_en | output | 1 | Device data-output enable, active high |

## Verification
Host reads, writes, selects without strobes and all-lines-low patterns are applied both while blocked and while granted. Comparing the two cases shows that the gate, and not the host pattern, decides what reaches the device. The power-up window is probed one edge before and at the grant edge, which pins down the two synchroniser stages and the exact length of the count. A supply drop in the middle of the count, a backup-switch pulse and an oscillator stop each separate a restarted lockout from a resumed one. A write held across a power loss shows that it is cut off and not resumed after recovery.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int NUM_LINES  = 4;
  // positions of the host lines inside the gated line vector
  localparam int LN_WR      = 0;
  localparam int LN_RD      = 1;
  localparam int LN_CS_MEM  = 2;
  localparam int LN_CS_TIME = 3;
  // flag positions inside the synchroniser vector
  localparam int FL_SUPPLY  = 0;
  localparam int FL_BACKUP  = 1;
  localparam int NUM_FLAGS  = 2;

  function automatic int ms_to_cycles(input int clk_hz, input int ms);
    return (clk_hz / 1000) * ms;
  endfunction
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pfg_lockout.sv
module pfg_lockout #(
  parameter int LOCK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic done
);
  localparam int CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!pwr_good) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  AST_LOSS_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !done); // R5
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R4
  AST_DONE_AFTER_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(cnt) == LAST && $past(pwr_good))); // R4
endmodule

// File: rtl/pfg_line_gate.sv
module pfg_line_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ok,
  input  logic host_n,
  output logic dev_n
);
  // armed: the host line has been seen idle since access was last lost
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= host_n | (armed & ok);
  end

  assign dev_n = ~(ok & armed & ~host_n);

  AST_NO_MIDCYCLE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !host_n && $past(!host_n && !ok)) |-> dev_n); // R8
endmodule

// File: rtl/pwrfail_access_gate.sv
module pwrfail_access_gate
  import pfg_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int LOCK_MS     = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_cs_time_n,
  input  logic host_cs_mem_n,
  input  logic host_rd_n,
  input  logic host_wr_n,
  input  logic supply_ok,
  input  logic on_backup,
  input  logic osc_run,
  output logic dev_cs_time_n,
  output logic dev_cs_mem_n,
  output logic dev_rd_n,
  output logic dev_wr_n,
  output logic dout_en
);
  localparam int LOCK_RAW    = ms_to_cycles(CLK_HZ, LOCK_MS);
  localparam int LOCK_CYCLES = (LOCK_RAW < 1) ? 1 : LOCK_RAW;

  logic [NUM_FLAGS-1:0] flags_async, flags_sync;
  logic                 pwr_good, lock_done, access_ok;
  logic [NUM_LINES-1:0] host_vec, dev_vec;

  assign flags_async[FL_SUPPLY] = supply_ok;
  assign flags_async[FL_BACKUP] = on_backup;

  pfg_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(flags_async), .sync_out(flags_sync)
  );

  assign pwr_good = flags_sync[FL_SUPPLY] & ~flags_sync[FL_BACKUP];

  pfg_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .done(lock_done)
  );

  assign access_ok = pwr_good & lock_done & osc_run;

  assign host_vec[LN_WR]      = host_wr_n;
  assign host_vec[LN_RD]      = host_rd_n;
  assign host_vec[LN_CS_MEM]  = host_cs_mem_n;
  assign host_vec[LN_CS_TIME] = host_cs_time_n;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    pfg_line_gate u_gate (
      .clk(clk), .rst_n(rst_n), .ok(access_ok),
      .host_n(host_vec[i]), .dev_n(dev_vec[i])
    );
  end

  assign dev_wr_n      = dev_vec[LN_WR];
  assign dev_rd_n      = dev_vec[LN_RD];
  assign dev_cs_mem_n  = dev_vec[LN_CS_MEM];
  assign dev_cs_time_n = dev_vec[LN_CS_TIME];

  assign dout_en = access_ok & ~dev_vec[LN_RD]
                 & (~dev_vec[LN_CS_TIME] | ~dev_vec[LN_CS_MEM]);

  AST_BLOCKED_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_sync[FL_SUPPLY] |-> (&dev_vec)); // R2
  AST_BLOCKED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_good && lock_done) |-> !dout_en); // R3
  AST_GRANT_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> ((&dev_vec) && !dout_en)); // R6
  AST_BACKUP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flags_sync[FL_BACKUP] |-> ((&dev_vec) && !dout_en)); // R7
endmodule

// File: tb/pwrfail_access_gate_bench.sv
`timescale 1ns/1ps
module pwrfail_access_gate_bench;
  localparam int CLK_HZ  = 1000;
  localparam int LOCK_MS = 20;
  localparam int L       = (CLK_HZ / 1000) * LOCK_MS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_t_n = 1'b1, cs_m_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic supply_ok = 1'b0, on_backup = 1'b0, osc_run = 1'b1;
  logic d_cs_t_n, d_cs_m_n, d_rd_n, d_wr_n, dout_en;
  logic [4:0] obs;
  int checks = 0, fails = 0;
  bit finished = 0;

  // obs = {cs_time, cs_mem, rd, wr, dout_en}
  localparam logic [4:0] IDLE      = 5'b11110;
  localparam logic [4:0] READ_MEM  = 5'b10011;
  localparam logic [4:0] WRITE_TIM = 5'b01100;

  always #2.5 clk = ~clk;

  pwrfail_access_gate #(.CLK_HZ(CLK_HZ), .LOCK_MS(LOCK_MS)) u_pwrfail_access_gate (
    .clk(clk), .rst_n(rst_n),
    .host_cs_time_n(cs_t_n), .host_cs_mem_n(cs_m_n),
    .host_rd_n(rd_n), .host_wr_n(wr_n),
    .supply_ok(supply_ok), .on_backup(on_backup), .osc_run(osc_run),
    .dev_cs_time_n(d_cs_t_n), .dev_cs_mem_n(d_cs_m_n),
    .dev_rd_n(d_rd_n), .dev_wr_n(d_wr_n), .dout_en(dout_en)
  );

  assign obs = {d_cs_t_n, d_cs_m_n, d_rd_n, d_wr_n, dout_en};

  task automatic chk(input string req, input logic [4:0] exp);
    checks++;
    if (obs !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, obs, exp);
    end
  endtask

  task automatic host(input logic ct, input logic cm, input logic r, input logic w);
    cs_t_n = ct; cs_m_n = cm; rd_n = r; wr_n = w;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // drive a pattern at a negedge, check, and return to idle before the next edge
  task automatic probe(input logic ct, input logic cm, input logic r, input logic w,
                       input logic [4:0] exp, input string req);
    host(ct, cm, r, w);
    #1 chk(req, exp);
    host(1, 1, 1, 1);
  endtask

  task automatic power_up();
    supply_ok = 1'b1;
    edges(L + 2);
  endtask

  task automatic t_reset();
    host(0, 0, 0, 0);
    rst_n = 1'b0;
    edges(3);
    chk("R1 reset lines idle", IDLE);
    host(1, 1, 1, 1);
    rst_n = 1'b1;
    edges(1);
    chk("R1 after release", IDLE);
  endtask

  task automatic t_blocked();
    probe(0, 0, 0, 0, IDLE, "R2 all host lines low while supply low");
    probe(1, 0, 0, 1, IDLE, "R2 read while supply low");
    probe(0, 1, 1, 0, IDLE, "R3 write while supply low, no drive");
  endtask

  task automatic t_powerup();
    supply_ok = 1'b1;
    edges(L + 1);
    probe(1, 0, 0, 1, IDLE, "R4 blocked at L+1 edges");
    edges(1);
    probe(1, 0, 0, 1, READ_MEM, "R4 granted at L+2 edges");
    probe(0, 1, 1, 0, WRITE_TIM, "R9 write passes same cycle");
    probe(1, 1, 0, 1, 5'b11010, "R3 read without select, no drive");
    probe(0, 1, 0, 1, 5'b01011, "R3 read of time registers drives");
  endtask

  task automatic t_drop_mid_lock();
    supply_ok = 1'b0;
    edges(4);
    supply_ok = 1'b1;
    edges(10);
    supply_ok = 1'b0;
    edges(3);
    supply_ok = 1'b1;
    edges(L + 1);
    probe(1, 0, 0, 1, IDLE, "R5 restarted count still blocked at L+1");
    edges(1);
    probe(1, 0, 0, 1, READ_MEM, "R5 granted after full count");
  endtask

  task automatic t_osc();
    osc_run = 1'b0;
    probe(1, 0, 0, 1, IDLE, "R6 oscillator stopped blocks");
    edges(3);
    probe(0, 1, 1, 0, IDLE, "R6 still blocked");
    osc_run = 1'b1;
    probe(1, 0, 0, 1, READ_MEM, "R6 oscillator running grants same cycle");
  endtask

  task automatic t_backup();
    on_backup = 1'b1;
    edges(1);
    probe(1, 0, 0, 1, READ_MEM, "R7 backup flag not yet through synchroniser");
    edges(1);
    probe(1, 0, 0, 1, IDLE, "R7 backup flag blocks");
    on_backup = 1'b0;
    edges(L + 1);
    probe(1, 0, 0, 1, IDLE, "R7 lockout restarts after backup");
    edges(1);
    probe(1, 0, 0, 1, READ_MEM, "R7 granted after backup lockout");
  endtask

  task automatic t_abort();
    host(0, 1, 1, 0);
    #1 chk("R9 write in progress", WRITE_TIM);
    supply_ok = 1'b0;
    edges(1);
    chk("R10 write passes one edge after drop", WRITE_TIM);
    edges(1);
    chk("R10 write aborted two edges after drop", IDLE);
    power_up();
    chk("R8 held write not resumed after recovery", IDLE);
    host(1, 1, 1, 1);
    edges(1);
    probe(0, 1, 1, 0, WRITE_TIM, "R8 fresh write after release passes");
  endtask

  initial begin
    t_reset();
    t_blocked();
    t_powerup();
    t_drop_mid_lock();
    t_osc();
    t_backup();
    t_abort();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule